// File: doc/BRIEF.md
# Supply voltage detection flag controller

This block turns the raw output of a supply comparator into two flags that software can read. The comparator output is 1 while the supply is below its threshold. The first flag is sticky and is cleared by writing 0. The second flag is a live status that follows the comparator. The block also drives an interrupt request and a wake source for STOP mode. The comparator output is first passed through a two-flop synchronizer; everything after it runs in the system clock domain.

While the core is in one of its low-power modes, both flags hold their values. They pick up the synchronized comparator level again once the mode is NORMAL or SLOW. The status flag is taken from an earlier point of the delay chain than the sticky flag, so the status flag leads by two cycles. A select field picks the source of the STOP release: the external STOP pin, or a one-cycle pulse when the supply recovers. When level release is selected, an inhibit output tells the mode controller that STOP must not be entered while the supply is good.

Top module: `supply_flag_ctrl`

## Requirements
- R1: When `det_en` is 1, the mode is awake (`op_mode` 0 = NORMAL or 1 = SLOW) and `below_raw` has been 1 for three clock edges, `det_flag` becomes 1 on the fourth edge.
- R2: Once set, `det_flag` stays 1 after `below_raw` returns to 0 and after `det_en` is cleared.
- R3: A write with `wr_en`=1 and `wr_data`=0 clears `det_flag` at the next edge. A write with `wr_data`=1 leaves it unchanged.
- R4: When `det_en` is 1 and the mode is awake, `stat_flag` equals `below_raw` delayed by two clock edges. It returns to 0 when the supply recovers.
- R5: While `det_en` is 0, a low supply sets neither flag, and `stat_flag` is driven to 0 at the next awake edge.
- R6: While `op_mode` is 2 (STOP), 3 (IDLE0) or 4 (SLEEP0), both flags hold their values; only a clearing write changes `det_flag`. On the first awake edge afterwards, both flags take the current synchronized level.
- R7: On a live drop of the supply, `stat_flag` rises two cycles before `det_flag`.
- R8: `irq` is a one-cycle pulse, high in the cycle in which `det_flag` rises, and only when `irq_mode` is 1.
- R9: With `rel_sel`=01, `irq_mode`=1, `det_en`=1 and `level_rel`=0, `stop_release` pulses for one cycle, two edges after `below_raw` falls. This pulse is produced in every mode, STOP included.
- R10: With `rel_sel`=01 and `level_rel`=1, `stop_release` stays 0, and `stop_inhibit` is 1 whenever the synchronized supply is at or above the threshold.
- R11: With `rel_sel`=00, `stop_release` follows `stop_pin` directly. With `rel_sel`=10 or 11, `stop_release` is 0.
- R12: If a clearing write falls in the same cycle as a set condition, the set wins and `det_flag` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| below_raw | input | 1 | Comparator output, asynchronous; 1 = supply below threshold |
| det_en | input | 1 | Detector enable |
| irq_mode | input | 1 | 1 = detector produces interrupts |
| wr_en | input | 1 | Write strobe for the sticky flag |
| wr_data | input | 1 | Write value; 0 clears the flag |
| rel_sel | input | 2 | STOP release source: 00 pin, 01 voltage detect, other none |
| op_mode | input | 3 | 0 NORMAL, 1 SLOW, 2 STOP, 3 IDLE0, 4 SLEEP0 |
| level_rel | input | 1 | 1 = level release mode, 0 = edge release mode |
| stop_pin | input | 1 | External STOP pin |
| det_flag | output | 1 | Sticky detection flag |
| stat_flag | output | 1 | Live detection status |
| irq | output | 1 | Interrupt request pulse |
| stop_release | output | 1 | STOP mode release |
| stop_inhibit | output | 1 | Blocks STOP entry while the supply is good in level mode |

## Verification
A clearing write to the sticky flag and a new set condition can fall in the same cycle. The bench holds `below_raw` high until the sticky flag is set, then writes 0 while the low supply is still present at the end of the delay chain. The flag must read 1 after that edge. The bench then lets the chain drain and repeats the write, which must now clear the flag, so the first result shows priority rather than a write that was lost.

// File: rtl/supply_flag_ctrl.sv
module supply_flag_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       below_raw,
  input  logic       det_en,
  input  logic       irq_mode,
  input  logic       wr_en,
  input  logic       wr_data,
  input  logic [1:0] rel_sel,
  input  logic [2:0] op_mode,
  input  logic       level_rel,
  input  logic       stop_pin,
  output logic       det_flag,
  output logic       stat_flag,
  output logic       irq,
  output logic       stop_release,
  output logic       stop_inhibit
);
  localparam logic [2:0] M_NORMAL = 3'd0;
  localparam logic [2:0] M_SLOW   = 3'd1;
  localparam logic [1:0] SEL_PIN  = 2'b00;
  localparam logic [1:0] SEL_VD   = 2'b01;

  logic s1, s2, s3;
  logic vdrel_q;

  wire awake   = (op_mode == M_NORMAL) || (op_mode == M_SLOW);
  wire clr_req = wr_en & ~wr_data;
  wire set_req = awake & det_en & s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1        <= 1'b0;
      s2        <= 1'b0;
      s3        <= 1'b0;
      stat_flag <= 1'b0;
      det_flag  <= 1'b0;
      irq       <= 1'b0;
      vdrel_q   <= 1'b0;
    end else begin
      s1 <= below_raw;
      s2 <= s1;
      s3 <= s2;
      if (awake) stat_flag <= det_en & s1;
      if (set_req)      det_flag <= 1'b1;
      else if (clr_req) det_flag <= 1'b0;
      irq     <= set_req & ~det_flag & irq_mode;
      vdrel_q <= det_en & irq_mode & ~level_rel & s2 & ~s1;
    end
  end

  always_comb begin
    case (rel_sel)
      SEL_PIN: stop_release = stop_pin;
      SEL_VD:  stop_release = vdrel_q;
      default: stop_release = 1'b0;
    endcase
  end

  assign stop_inhibit = (rel_sel == SEL_VD) & level_rel & ~s2;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    det_flag && !(wr_en && !wr_data) |=> det_flag);

  p_sleep_stat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !awake |=> $stable(stat_flag));

  p_sleep_det_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !awake && !clr_req |=> $stable(det_flag));

  p_no_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en && !det_flag |=> !det_flag);

  p_irq_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_irq_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> det_flag && irq_mode);

  p_level_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_inhibit |-> !stop_release);
endmodule

// File: tb/supply_flag_ctrl_bench.sv
module supply_flag_ctrl_bench;
  logic clk = 0, rst_n = 0;
  logic below_raw = 0, det_en = 0, irq_mode = 0, wr_en = 0, wr_data = 0;
  logic [1:0] rel_sel = 2'b00;
  logic [2:0] op_mode = 3'd0;
  logic level_rel = 0, stop_pin = 0;
  logic det_flag, stat_flag, irq, stop_release, stop_inhibit;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  supply_flag_ctrl u_supply_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .below_raw(below_raw), .det_en(det_en),
    .irq_mode(irq_mode), .wr_en(wr_en), .wr_data(wr_data), .rel_sel(rel_sel),
    .op_mode(op_mode), .level_rel(level_rel), .stop_pin(stop_pin),
    .det_flag(det_flag), .stat_flag(stat_flag), .irq(irq),
    .stop_release(stop_release), .stop_inhibit(stop_inhibit));

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic d);
    wr_en = 1; wr_data = d;
    step(1);
    wr_en = 0; wr_data = 0;
  endtask

  task automatic clear_all();
    below_raw = 0;
    step(4);
    wr(0);
  endtask

  task automatic t_reset();
    chk("reset det_flag", det_flag, 0);
    chk("reset stat_flag", stat_flag, 0);
    chk("reset irq", irq, 0);
    chk("reset stop_inhibit", stop_inhibit, 0);
  endtask

  task automatic t_live_drop();
    det_en = 1; irq_mode = 1;
    below_raw = 1;
    step(1);
    chk("R4 stat after 1 edge", stat_flag, 0);
    step(1);
    chk("R4 stat after 2 edges", stat_flag, 1);
    chk("R7 det lags stat", det_flag, 0);
    step(1);
    chk("R7 det still 0 at edge 3", det_flag, 0);
    step(1);
    chk("R1 det set at edge 4", det_flag, 1);
    chk("R8 irq pulse", irq, 1);
    step(1);
    chk("R8 irq one cycle", irq, 0);
    below_raw = 0;
    step(2);
    chk("R4 stat returns to 0", stat_flag, 0);
    chk("R2 det holds after recovery", det_flag, 1);
    det_en = 0;
    step(1);
    chk("R2 det holds with enable cleared", det_flag, 1);
    det_en = 1;
  endtask

  task automatic t_write();
    wr(1);
    chk("R3 write 1 no effect", det_flag, 1);
    wr(0);
    chk("R3 write 0 clears", det_flag, 0);
  endtask

  task automatic t_disabled();
    det_en = 0;
    below_raw = 1;
    step(6);
    chk("R5 det not set when disabled", det_flag, 0);
    chk("R5 stat not set when disabled", stat_flag, 0);
    det_en = 1;
    clear_all();
  endtask

  task automatic t_sleep();
    op_mode = 3'd2;
    below_raw = 1;
    step(6);
    chk("R6 stat held in STOP", stat_flag, 0);
    chk("R6 det held in STOP", det_flag, 0);
    op_mode = 3'd4;
    step(2);
    chk("R6 det held in SLEEP0", det_flag, 0);
    op_mode = 3'd1;
    step(1);
    chk("R6 stat updates after wake", stat_flag, 1);
    chk("R6 det updates after wake", det_flag, 1);
    op_mode = 3'd0;
  endtask

  task automatic t_collide();
    wr(0);
    chk("R12 set wins over clear", det_flag, 1);
    below_raw = 0;
    step(4);
    wr(0);
    chk("R12 clear after drain", det_flag, 0);
  endtask

  task automatic t_irq_off();
    irq_mode = 0;
    below_raw = 1;
    step(4);
    chk("R8 det set without irq mode", det_flag, 1);
    chk("R8 no irq without irq mode", irq, 0);
    irq_mode = 1;
    clear_all();
  endtask

  task automatic t_vd_edge();
    rel_sel = 2'b01; level_rel = 0; op_mode = 3'd2;
    below_raw = 1;
    step(3);
    below_raw = 0;
    step(1);
    chk("R9 no release at edge 1", stop_release, 0);
    step(1);
    chk("R9 release pulse at edge 2", stop_release, 1);
    step(1);
    chk("R9 release one cycle", stop_release, 0);
    chk("R9 no inhibit in edge mode", stop_inhibit, 0);
    op_mode = 3'd0;
    wr(0);
  endtask

  task automatic t_vd_level();
    level_rel = 1;
    step(1);
    chk("R10 inhibit while supply good", stop_inhibit, 1);
    below_raw = 1;
    step(2);
    chk("R10 inhibit drops when low", stop_inhibit, 0);
    below_raw = 0;
    step(2);
    chk("R10 no release in level mode", stop_release, 0);
    chk("R10 inhibit back", stop_inhibit, 1);
    level_rel = 0;
    step(3);
    wr(0);
  endtask

  task automatic t_pin();
    rel_sel = 2'b00; stop_pin = 1; #1;
    chk("R11 pin routed high", stop_release, 1);
    stop_pin = 0; #1;
    chk("R11 pin routed low", stop_release, 0);
    rel_sel = 2'b10; stop_pin = 1; #1;
    chk("R11 select 10 gives 0", stop_release, 0);
    rel_sel = 2'b11; #1;
    chk("R11 select 11 gives 0", stop_release, 0);
    rel_sel = 2'b00; stop_pin = 0;
  endtask

  initial begin
    step(2);
    rst_n = 1;
    step(1);
    t_reset();
    t_live_drop();
    t_write();
    t_disabled();
    t_sleep();
    t_collide();
    t_irq_off();
    t_vd_edge();
    t_vd_level();
    t_pin();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule